// File: doc/BRIEF.md
# Bit-Sliced Bus Interface Register

This block is a registered bridge between a shared backplane bus and a local module bus. The local side uses two one-way buses: an outbound bus that the module drives and an inbound bus the block presents to the module. Toward the backplane it has three kinds of bit slices. A 24-bit data path is driven onto the backplane only while an arbiter grant belonging to this chip is active. A 2-bit request path is always driven, with no grant involved. A single wired-OR status bit is likewise always driven.

The data and request slices are linked into one serial scan chain. The wired-OR slice stays outside that chain. The arbiter provides one grant line for each of four slaves, and a parameter mask selects which of them this chip serves. A global stop input freezes every register and withdraws all backplane output enables. Tristate drive is modelled as a value output paired with a separate output-enable signal.

Top module: `bus_slice_register`

## Requirements
- R1: `bp_data_oe` is high exactly when internal reset is released, `arb_stop` is low and at least one grant bit selected by `GNT_MASK` is high. With the default mask `4'b0011`, `grant[0]` and `grant[1]` belong to this chip, and `grant[2]` and `grant[3]` have no effect on drive or capture.
- R2: At each clock edge where the chip is granted, `arb_stop` is low and `scan_en` is low, all 24 bits of `loc_out_data` load together into the data register. `bp_data_out` shows them after that edge.
- R3: At each clock edge where the chip is not granted, `arb_stop` is low and `scan_en` is low, `bp_data_in` is captured into the data register. It is visible on `bp_data_out` after that edge and on `loc_in_data` after the following edge. `loc_in_data` only ever takes words captured from the backplane.
- R4: At each edge with `arb_stop` low and `scan_en` low, `loc_req` loads into `bp_req_out` whatever the grants are. `bp_req_oe` is high whenever internal reset is released and `arb_stop` is low.
- R5: At each edge with `arb_stop` low, `loc_wor` loads into `bp_wor_out`, also while scanning. `bp_wor_oe` follows the same rule as `bp_req_oe`.
- R6: At each edge with `scan_en` high and `arb_stop` low, the chain shifts one place: `scan_in` goes to data bit 0, data bit i goes to bit i+1, data bit 23 goes to request bit 0, and request bit 0 goes to request bit 1. `scan_out` is request bit 1. No backplane word or `loc_req` value is captured during the shift.
- R7: While `arb_stop` is high, every register holds its value and all three output enables are low. Stop takes priority over scan and grant.
- R8: While `rst_n` is low, all registers are zero and all output enables are low. The enables stay low until the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 4 | Per-slave arbiter grants |
| arb_stop | input | 1 | Arbiter stop: freeze and release the bus |
| scan_en | input | 1 | Scan shift mode |
| scan_in | input | 1 | Serial scan input |
| scan_out | output | 1 | Serial scan output (request bit 1) |
| bp_data_in | input | 24 | Data received from the backplane |
| bp_data_out | output | 24 | Data register value toward the backplane |
| bp_data_oe | output | 1 | Backplane data drive enable |
| bp_req_out | output | 2 | Request register value toward the backplane |
| bp_req_oe | output | 1 | Request drive enable |
| bp_wor_out | output | 1 | Wired-OR status value |
| bp_wor_oe | output | 1 | Wired-OR drive enable |
| loc_out_data | input | 24 | Local outbound bus from the module |
| loc_in_data | output | 24 | Local inbound bus to the module |
| loc_req | input | 2 | Local request bits |
| loc_wor | input | 1 | Local wired-OR status |

## Verification
The output enables are combinational, so they are sampled one time step after the grant, stop or reset input changes, within the same cycle. Register results (`bp_data_out`, `bp_req_out`, `bp_wor_out`, `scan_out`) are due after the one edge that follows the stimulus. `loc_in_data` is due after the second edge. The enable release after reset is due after the second edge as well. All inputs change on the falling edge, and every register check is made on the falling edge after exactly the counted number of rising edges. For the scan chain, `scan_out` is compared before each shift against the bit position that the shift order predicts.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // Per-slice register operation selected each cycle
  typedef enum logic [1:0] {
    SL_HOLD  = 2'd0,
    SL_SHIFT = 2'd1,
    SL_LOCAL = 2'd2,
    SL_BACK  = 2'd3
  } slice_op_e;
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/bsr_slice.sv
module bsr_slice
  import bsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slice_op_e op,
  input  logic      sin,
  input  logic      loc_bit,
  input  logic      bp_bit,
  output logic      q
);
  logic q_d;

  always_comb begin
    case (op)
      SL_SHIFT: q_d = sin;
      SL_LOCAL: q_d = loc_bit;
      SL_BACK:  q_d = bp_bit;
      default:  q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int                 NUM_GNT  = 4,
  parameter logic [NUM_GNT-1:0] GNT_MASK = 4'b0011
) (
  input  logic               rst_q_n,
  input  logic [NUM_GNT-1:0] grant,
  input  logic               arb_stop,
  input  logic               scan_en,
  output slice_op_e          data_op,
  output slice_op_e          req_op,
  output slice_op_e          wor_op,
  output logic               data_oe,
  output logic               req_oe,
  output logic               wor_oe
);
  logic granted;
  logic active;

  assign granted = |(grant & GNT_MASK);
  assign active  = rst_q_n & ~arb_stop;

  always_comb begin
    if (arb_stop)     data_op = SL_HOLD;
    else if (scan_en) data_op = SL_SHIFT;
    else if (granted) data_op = SL_LOCAL;
    else              data_op = SL_BACK;

    if (arb_stop)     req_op = SL_HOLD;
    else if (scan_en) req_op = SL_SHIFT;
    else              req_op = SL_LOCAL;

    if (arb_stop)     wor_op = SL_HOLD;
    else              wor_op = SL_LOCAL;
  end

  assign data_oe = active & granted;
  assign req_oe  = active;
  assign wor_oe  = active;
endmodule

// File: rtl/bsr_inbound_stage.sv
module bsr_inbound_stage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_in,
  input  logic         hold,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic         fresh_q;
  logic         fresh_d;
  logic         stage_en;
  logic [W-1:0] q_d;

  // fresh_q marks that the data register holds a word from the backplane
  always_comb begin
    fresh_d  = hold ? fresh_q : cap_in;
    stage_en = fresh_q & ~hold;
    q_d      = stage_en ? d_in : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      q       <= '0;
    end else begin
      fresh_q <= fresh_d;
      q       <= q_d;
    end
  end
endmodule

// File: rtl/bus_slice_register.sv
module bus_slice_register
  import bsr_pkg::*;
#(
  parameter int                 DATA_W   = 24,
  parameter int                 REQ_W    = 2,
  parameter int                 NUM_GNT  = 4,
  parameter logic [NUM_GNT-1:0] GNT_MASK = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GNT-1:0] grant,
  input  logic               arb_stop,
  input  logic               scan_en,
  input  logic               scan_in,
  output logic               scan_out,
  input  logic [DATA_W-1:0]  bp_data_in,
  output logic [DATA_W-1:0]  bp_data_out,
  output logic               bp_data_oe,
  output logic [REQ_W-1:0]   bp_req_out,
  output logic               bp_req_oe,
  output logic               bp_wor_out,
  output logic               bp_wor_oe,
  input  logic [DATA_W-1:0]  loc_out_data,
  output logic [DATA_W-1:0]  loc_in_data,
  input  logic [REQ_W-1:0]   loc_req,
  input  logic               loc_wor
);
  localparam int CHAIN_W = DATA_W + REQ_W;

  logic               rst_q_n;
  slice_op_e          data_op;
  slice_op_e          req_op;
  slice_op_e          wor_op;
  logic [CHAIN_W-1:0] chain_q;

  bsr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bsr_ctrl #(
    .NUM_GNT  (NUM_GNT),
    .GNT_MASK (GNT_MASK)
  ) u_ctrl (
    .rst_q_n  (rst_q_n),
    .grant    (grant),
    .arb_stop (arb_stop),
    .scan_en  (scan_en),
    .data_op  (data_op),
    .req_op   (req_op),
    .wor_op   (wor_op),
    .data_oe  (bp_data_oe),
    .req_oe   (bp_req_oe),
    .wor_oe   (bp_wor_oe)
  );

  // Scan-linked slices: data bits first, then request bits
  for (genvar i = 0; i < CHAIN_W; i++) begin : g_slice
    logic sin;
    if (i == 0) begin : g_head
      assign sin = scan_in;
    end else begin : g_link
      assign sin = chain_q[i-1];
    end

    if (i < DATA_W) begin : g_data
      bsr_slice u_bit (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .op      (data_op),
        .sin     (sin),
        .loc_bit (loc_out_data[i]),
        .bp_bit  (bp_data_in[i]),
        .q       (chain_q[i])
      );
    end else begin : g_req
      bsr_slice u_bit (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .op      (req_op),
        .sin     (sin),
        .loc_bit (loc_req[i-DATA_W]),
        .bp_bit  (1'b0),
        .q       (chain_q[i])
      );
    end
  end

  // Wired-OR slice: outside the chain, never grant-gated
  bsr_slice u_wor (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .op      (wor_op),
    .sin     (1'b0),
    .loc_bit (loc_wor),
    .bp_bit  (1'b0),
    .q       (bp_wor_out)
  );

  bsr_inbound_stage #(
    .W (DATA_W)
  ) u_inb (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .cap_in (data_op == SL_BACK),
    .hold   (arb_stop),
    .d_in   (chain_q[DATA_W-1:0]),
    .q      (loc_in_data)
  );

  assign bp_data_out = chain_q[DATA_W-1:0];
  assign bp_req_out  = chain_q[CHAIN_W-1:DATA_W];
  assign scan_out    = chain_q[CHAIN_W-1];
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int                 DATA_W   = 24,
  parameter int                 REQ_W    = 2,
  parameter int                 NUM_GNT  = 4,
  parameter logic [NUM_GNT-1:0] GNT_MASK = 4'b0011
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [NUM_GNT-1:0] grant,
  input logic               arb_stop,
  input logic               scan_en,
  input logic               scan_in,
  input logic               scan_out,
  input logic [DATA_W-1:0]  bp_data_in,
  input logic [DATA_W-1:0]  bp_data_out,
  input logic               bp_data_oe,
  input logic [REQ_W-1:0]   bp_req_out,
  input logic               bp_req_oe,
  input logic               bp_wor_out,
  input logic               bp_wor_oe,
  input logic [DATA_W-1:0]  loc_out_data,
  input logic [DATA_W-1:0]  loc_in_data,
  input logic [REQ_W-1:0]   loc_req,
  input logic               loc_wor
);
  logic mine;
  assign mine = |(grant & GNT_MASK);

  p_no_foreign_grant_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mine |-> !bp_data_oe);

  p_data_oe_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mine && !arb_stop) |-> bp_data_oe);

  p_outbound_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mine && !arb_stop && !scan_en) |=> bp_data_out == $past(loc_out_data));

  p_inbound_pipe_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n, 2) && $past(!mine && !arb_stop && !scan_en, 2) && $past(!arb_stop, 1))
      |-> loc_in_data == $past(bp_data_in, 2));

  p_req_load_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!arb_stop && !scan_en) |=> bp_req_out == $past(loc_req));

  p_req_oe_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !arb_stop |-> bp_req_oe);

  p_wor_load_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !arb_stop |=> bp_wor_out == $past(loc_wor) && bp_wor_oe == 1'b0 || bp_wor_out == $past(loc_wor));

  p_scan_shift_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (scan_en && !arb_stop) |=> (bp_data_out[0] == $past(scan_in))
      && (bp_req_out[0] == $past(bp_data_out[DATA_W-1]))
      && (scan_out == $past(bp_req_out[0])));

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    arb_stop |=> $stable(bp_data_out) && $stable(bp_req_out)
      && $stable(bp_wor_out) && $stable(loc_in_data));

  p_stop_oe_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    arb_stop |-> !bp_data_oe && !bp_req_oe && !bp_wor_oe);

  p_reset_oe_r8: assert property (@(posedge clk)
    !rst_q_n |-> !bp_data_oe && !bp_req_oe && !bp_wor_oe);
endmodule

bind bus_slice_register bsr_checker #(
  .DATA_W   (DATA_W),
  .REQ_W    (REQ_W),
  .NUM_GNT  (NUM_GNT),
  .GNT_MASK (GNT_MASK)
) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .grant        (grant),
  .arb_stop     (arb_stop),
  .scan_en      (scan_en),
  .scan_in      (scan_in),
  .scan_out     (scan_out),
  .bp_data_in   (bp_data_in),
  .bp_data_out  (bp_data_out),
  .bp_data_oe   (bp_data_oe),
  .bp_req_out   (bp_req_out),
  .bp_req_oe    (bp_req_oe),
  .bp_wor_out   (bp_wor_out),
  .bp_wor_oe    (bp_wor_oe),
  .loc_out_data (loc_out_data),
  .loc_in_data  (loc_in_data),
  .loc_req      (loc_req),
  .loc_wor      (loc_wor)
);

// File: tb/bus_slice_register_test.sv
`timescale 1ns/1ps
module bus_slice_register_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  grant;
  logic        arb_stop, scan_en, scan_in, scan_out;
  logic [23:0] bp_data_in, bp_data_out, loc_out_data, loc_in_data;
  logic        bp_data_oe, bp_req_oe, bp_wor_out, bp_wor_oe, loc_wor;
  logic [1:0]  bp_req_out, loc_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  bus_slice_register uut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .arb_stop(arb_stop),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .bp_data_in(bp_data_in), .bp_data_out(bp_data_out), .bp_data_oe(bp_data_oe),
    .bp_req_out(bp_req_out), .bp_req_oe(bp_req_oe),
    .bp_wor_out(bp_wor_out), .bp_wor_oe(bp_wor_oe),
    .loc_out_data(loc_out_data), .loc_in_data(loc_in_data),
    .loc_req(loc_req), .loc_wor(loc_wor)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one rising edge, then back to the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; grant = '0; arb_stop = 0; scan_en = 0; scan_in = 0;
    bp_data_in = '0; loc_out_data = '0; loc_req = '0; loc_wor = 0;
    repeat (3) step();
    check("R8 data reset", 32'(bp_data_out), 0);
    check("R8 inbound reset", 32'(loc_in_data), 0);
    check("R8 req oe in reset", 32'(bp_req_oe), 0);
    rst_n = 1'b1;
    step();
    check("R8 oe low one edge after release", 32'(bp_req_oe), 0);
    step();
    check("R8 oe high two edges after release", 32'(bp_req_oe), 1);
    check("R8 wor oe two edges after release", 32'(bp_wor_oe), 1);
    step();
  endtask

  task automatic t_inbound();
    grant = '0;
    bp_data_in = 24'hA1B2C3; step();
    check("R3 captured on register", 32'(bp_data_out), 32'hA1B2C3);
    bp_data_in = 24'h5E6F70; step();
    check("R3 inbound one cycle later", 32'(loc_in_data), 32'hA1B2C3);
    check("R3 second capture", 32'(bp_data_out), 32'h5E6F70);
    check("R1 no drive without grant", 32'(bp_data_oe), 0);
    bp_data_in = 24'h0F0F0F; step();
    check("R3 inbound follows", 32'(loc_in_data), 32'h5E6F70);
  endtask

  task automatic t_grant();
    bp_data_in = 24'h123456; grant = '0; step();
    grant = 4'b0100; loc_out_data = 24'hCAFE01; #1;
    check("R1 foreign grant no drive", 32'(bp_data_oe), 0);
    @(negedge clk); step();
    check("R1 foreign grant keeps inbound capture", 32'(bp_data_out), 32'h123456);
    grant = 4'b0001; #1;
    check("R1 own grant0 drives", 32'(bp_data_oe), 1);
    @(negedge clk); step();
    check("R2 outbound loaded", 32'(bp_data_out), 32'hCAFE01);
    grant = 4'b0010; loc_out_data = 24'hBEEF99; step();
    check("R2 outbound second word", 32'(bp_data_out), 32'hBEEF99);
    check("R1 own grant1 drives", 32'(bp_data_oe), 1);
    check("R3 inbound keeps backplane word while granted", 32'(loc_in_data), 32'h123456);
    grant = '0; step();
  endtask

  task automatic t_request();
    grant = '0; loc_req = 2'b10; step();
    check("R4 request loaded", 32'(bp_req_out), 2);
    check("R4 request oe", 32'(bp_req_oe), 1);
    grant = 4'b0001; loc_req = 2'b01; step();
    check("R4 request independent of grant", 32'(bp_req_out), 1);
    grant = '0; step();
  endtask

  task automatic t_wor();
    loc_wor = 1'b1; step();
    check("R5 wor loaded", 32'(bp_wor_out), 1);
    check("R5 wor oe", 32'(bp_wor_oe), 1);
    scan_en = 1'b1; loc_wor = 1'b0; step();
    check("R5 wor loads during scan", 32'(bp_wor_out), 0);
    scan_en = 1'b0; step();
  endtask

  task automatic t_stop();
    grant = 4'b0001; loc_out_data = 24'h777111; loc_req = 2'b11; loc_wor = 1'b1; step();
    arb_stop = 1'b1; #1;
    check("R7 data oe low in stop", 32'(bp_data_oe), 0);
    check("R7 req oe low in stop", 32'(bp_req_oe), 0);
    check("R7 wor oe low in stop", 32'(bp_wor_oe), 0);
    @(negedge clk);
    loc_out_data = 24'h000222; loc_req = 2'b00; loc_wor = 1'b0; scan_en = 1'b1;
    bp_data_in = 24'hDEAD00;
    step(); step();
    check("R7 data held", 32'(bp_data_out), 32'h777111);
    check("R7 request held", 32'(bp_req_out), 3);
    check("R7 wor held", 32'(bp_wor_out), 1);
    arb_stop = 1'b0; scan_en = 1'b0; grant = '0; step();
  endtask

  task automatic t_scan();
    logic [25:0] v;
    logic [25:0] w;
    grant = '0; bp_data_in = 24'h9C3A5F; loc_req = 2'b01; step();
    v = {2'b01, 24'h9C3A5F};
    w = 26'h2B4D1E7;
    scan_en = 1'b1; bp_data_in = 24'h111111; loc_req = 2'b10;
    for (int k = 0; k < 26; k++) begin
      check("R6 scan_out order", 32'(scan_out), 32'(v[25-k]));
      scan_in = w[25-k];
      step();
    end
    check("R6 data after shift", 32'(bp_data_out), 32'(w[23:0]));
    check("R6 request after shift", 32'(bp_req_out), 32'(w[25:24]));
    check("R6 no capture during scan", 32'(loc_in_data), 32'h9C3A5F);
    scan_en = 1'b0; step();
  endtask

  initial begin
    t_reset();
    t_inbound();
    t_grant();
    t_request();
    t_wor();
    t_stop();
    t_scan();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule